// File: doc/BRIEF.md
# SPI Clock Prescaler Setting Calculator

This block turns a requested maximum serial clock rate into the two settings that an SPI clock generator needs. The generator divides its source clock by `4 * (pm + 1)`, and it can put an extra divide-by-16 stage ahead of that. Given the source frequency and the requested frequency, the calculator chooses whether the extra stage is used and which 4-bit modulus to load. It chooses the fastest serial clock that does not run faster than the request. It uses ceiling division for this, not truncating division. Truncation rounds the modulus down, and the clock then comes out faster than the request whenever the ratio is not a whole number.

A one-cycle `start` pulse captures both frequencies. A restoring divider then produces one quotient bit per clock. The three result outputs are registered and hold their values until the next result is written, and `done` pulses once when they are updated. If the request is too slow to reach even with the extra stage and the largest modulus, the settings clamp to the slowest choice and `too_slow` is raised. The generator itself is not part of this block.

Top module: `spi_rate_calc`

## Requirements
- R1: During and after reset, `div16`, `pm`, `too_slow` and `done` are all 0 until the first result is written.
- R2: For a nonzero request, `div16` is 1 exactly when `src_hz > 64 * req_hz`. A ratio of exactly 64 keeps `div16` at 0.
- R3: When `div16` is 0, `pm` equals `ceil(src_hz / (4 * req_hz)) - 1`. The derived clock `src_hz / (4 * (pm + 1))` never exceeds `req_hz`. When the source divides exactly, `pm` equals the truncated quotient minus one. Example: source 133333332 with request 10000000 gives `pm` = 3, not 2.
- R4: When `div16` is 1 and the count `ceil(src_hz / (64 * req_hz))` is at most 16, `pm` equals that count minus one and `too_slow` is 0.
- R5: When `div16` is 1 and that count is above 16, `pm` is clamped to 15 and `too_slow` is 1. A count of exactly 16 is not clamped.
- R6: `too_slow` is 1 only together with `div16` = 1 and `pm` = 15.
- R7: A request of 0 gives `div16` = 1, `pm` = 15 and `too_slow` = 1.
- R8: A source of 0 with a nonzero request gives `div16` = 0, `pm` = 0 and `too_slow` = 0.
- R9: `done` is high for exactly one cycle. It is sampled high at the 34th falling clock edge after the rising edge that accepted `start`. The three result outputs change only in the cycle `done` is high.
- R10: A `start` pulse that arrives while a calculation is running is ignored. No extra `done` follows, and the result belongs to the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that captures `src_hz` and `req_hz` |
| src_hz | input | 32 | Source clock frequency of the baud-rate generator |
| req_hz | input | 32 | Requested maximum serial clock frequency |
| div16 | output | 1 | Use the extra divide-by-16 prescale |
| pm | output | 4 | Prescale modulus; the generator divides by 4*(pm+1) |
| too_slow | output | 1 | Request cannot be reached; settings are clamped to the slowest |
| done | output | 1 | One-cycle pulse when the result outputs are updated |

## Verification
The directed cases target the rounding decision. Exact ratios must match truncating division, and non-exact ratios such as 133333332 over 10000000 must come out one step slower. The ratio boundary at exactly 64 and at 64 plus one tells the two prescale paths apart, and a coarse count of exactly 16 versus 17 tells a legal maximum from a clamp. A zero request, a zero source and all-ones operands exercise the special results and the full operand width. Random operand pairs, with the request scaled from the source by random shifts, cover both paths, and each result is compared against a bench model and checked to confirm the derived clock does not exceed the request. A start pulse injected in the middle of a calculation shows whether the busy guard holds.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

  // Which divide chain the result uses
  typedef enum logic {
    PATH_FINE   = 1'b0,  // generator divides source by 4*(pm+1)
    PATH_COARSE = 1'b1   // extra /16 ahead: source / (64*(pm+1))
  } path_e;

  // Default geometry, shared by the modules
  localparam int DEF_FREQ_W       = 32;
  localparam int DEF_PM_W         = 4;
  localparam int DEF_FINE_SHIFT   = 2;  // log2 of 4
  localparam int DEF_COARSE_SHIFT = 6;  // log2 of 16*4
  localparam int DEF_RATIO_SHIFT  = 6;  // log2 of the ratio limit 64

endpackage

// File: rtl/spi_rate_range.sv
module spi_rate_range
  import spi_rate_pkg::*;
#(
  parameter int FREQ_W       = DEF_FREQ_W,
  parameter int FINE_SHIFT   = DEF_FINE_SHIFT,
  parameter int COARSE_SHIFT = DEF_COARSE_SHIFT,
  parameter int RATIO_SHIFT  = DEF_RATIO_SHIFT,
  localparam int DEN_W       = FREQ_W + COARSE_SHIFT
) (
  input  logic [FREQ_W-1:0] src_hz,
  input  logic [FREQ_W-1:0] req_hz,
  output path_e             path,
  output logic [FREQ_W-1:0] numer,
  output logic [DEN_W-1:0]  denom,
  output logic              src_zero,
  output logic              req_zero
);

  localparam int LIM_W = FREQ_W + RATIO_SHIFT;

  logic [LIM_W-1:0] ratio_lim;
  logic [LIM_W-1:0] src_ext;
  logic [DEN_W-1:0] den_fine;
  logic [DEN_W-1:0] den_coarse;

  // src > 64*req, with the product held at full width
  assign ratio_lim = {req_hz, {RATIO_SHIFT{1'b0}}};
  assign src_ext   = LIM_W'(src_hz);

  assign den_fine   = DEN_W'({req_hz, {FINE_SHIFT{1'b0}}});
  assign den_coarse = {req_hz, {COARSE_SHIFT{1'b0}}};

  assign src_zero = (src_hz == '0);
  assign req_zero = (req_hz == '0);

  always_comb begin
    path  = (src_ext > ratio_lim) ? PATH_COARSE : PATH_FINE;
    denom = (path == PATH_COARSE) ? den_coarse : den_fine;
    // ceil(a/b) = (a-1)/b + 1; a zero source is handled downstream
    numer = src_hz - FREQ_W'(1);
  end

endmodule

// File: rtl/spi_rate_divider.sv
module spi_rate_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 38,
  localparam int CNT_W = $clog2(NUM_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quot,
  output logic             busy,
  output logic             fin
);

  logic [NUM_W-1:0] acc;    // numerator shifts out, quotient shifts in
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  assign trial = {rem, acc[NUM_W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign fits  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      rem     <= '0;
      den_q   <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        acc     <= numer;
        rem     <= '0;
        den_q   <= denom;
        bit_cnt <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        acc     <= {acc[NUM_W-2:0], fits};
        rem     <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (bit_cnt == CNT_W'(NUM_W-1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quot = acc;

endmodule

// File: rtl/spi_rate_encode.sv
module spi_rate_encode
  import spi_rate_pkg::*;
#(
  parameter int FREQ_W = DEF_FREQ_W,
  parameter int PM_W   = DEF_PM_W
) (
  input  logic [FREQ_W-1:0] quot,
  input  path_e             path,
  input  logic              src_zero,
  input  logic              req_zero,
  output logic              div16,
  output logic [PM_W-1:0]   pm,
  output logic              too_slow
);

  localparam int CNT_W     = FREQ_W + 1;
  localparam int MAX_COUNT = 1 << PM_W;

  logic [CNT_W-1:0] count;

  assign count = {1'b0, quot} + CNT_W'(1);

  always_comb begin
    div16    = (path == PATH_COARSE);
    pm       = '0;
    too_slow = 1'b0;
    if (req_zero) begin
      div16    = 1'b1;
      pm       = '1;
      too_slow = 1'b1;
    end else if (src_zero) begin
      div16 = 1'b0;
    end else if (count > CNT_W'(MAX_COUNT)) begin
      pm       = '1;
      too_slow = (path == PATH_COARSE);
    end else begin
      pm = PM_W'(count - CNT_W'(1));
    end
  end

endmodule

// File: rtl/spi_rate_calc.sv
module spi_rate_calc
  import spi_rate_pkg::*;
#(
  parameter int FREQ_W       = DEF_FREQ_W,
  parameter int PM_W         = DEF_PM_W,
  parameter int FINE_SHIFT   = DEF_FINE_SHIFT,
  parameter int COARSE_SHIFT = DEF_COARSE_SHIFT,
  parameter int RATIO_SHIFT  = DEF_RATIO_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] src_hz,
  input  logic [FREQ_W-1:0] req_hz,
  output logic              div16,
  output logic [PM_W-1:0]   pm,
  output logic              too_slow,
  output logic              done
);

  localparam int DEN_W = FREQ_W + COARSE_SHIFT;

  path_e             path_in, path_q;
  logic [FREQ_W-1:0] numer;
  logic [DEN_W-1:0]  denom;
  logic              src_zero_in, req_zero_in;
  logic              src_zero_q, req_zero_q;
  logic [FREQ_W-1:0] quot;
  logic              div_busy, div_fin;
  logic              start_ok;
  logic              enc_div16, enc_slow;
  logic [PM_W-1:0]   enc_pm;

  // a start during a running calculation is dropped
  assign start_ok = start && !div_busy && !div_fin;

  spi_rate_range #(
    .FREQ_W(FREQ_W), .FINE_SHIFT(FINE_SHIFT),
    .COARSE_SHIFT(COARSE_SHIFT), .RATIO_SHIFT(RATIO_SHIFT)
  ) u_range (
    .src_hz(src_hz), .req_hz(req_hz), .path(path_in),
    .numer(numer), .denom(denom),
    .src_zero(src_zero_in), .req_zero(req_zero_in)
  );

  spi_rate_divider #(.NUM_W(FREQ_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .load(start_ok),
    .numer(numer), .denom(denom),
    .quot(quot), .busy(div_busy), .fin(div_fin)
  );

  spi_rate_encode #(.FREQ_W(FREQ_W), .PM_W(PM_W)) u_enc (
    .quot(quot), .path(path_q),
    .src_zero(src_zero_q), .req_zero(req_zero_q),
    .div16(enc_div16), .pm(enc_pm), .too_slow(enc_slow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      path_q     <= PATH_FINE;
      src_zero_q <= 1'b0;
      req_zero_q <= 1'b0;
      div16      <= 1'b0;
      pm         <= '0;
      too_slow   <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        path_q     <= path_in;
        src_zero_q <= src_zero_in;
        req_zero_q <= req_zero_in;
      end
      if (div_fin) begin
        div16    <= enc_div16;
        pm       <= enc_pm;
        too_slow <= enc_slow;
        done     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_rate_calc_sva.sv
module spi_rate_calc_sva #(
  parameter int FREQ_W = 32,
  parameter int PM_W   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            start_ok,
  input logic            req_zero_q,
  input logic            div16,
  input logic [PM_W-1:0] pm,
  input logic            too_slow,
  input logic            done
);

  localparam int LAT   = FREQ_W + 2;
  localparam int CYC_W = $clog2(LAT + 2) + 1;

  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)                cyc <= '0;
    else if (start_ok)      cyc <= CYC_W'(1);
    else if (done)          cyc <= '0;
    else if (cyc != '0)     cyc <= cyc + CYC_W'(1);
  end

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: done arrives a fixed number of cycles after an accepted start
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == CYC_W'(LAT)));

  // R9: results hold outside the done cycle
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({div16, pm, too_slow}));

  // R6: too_slow only with the slowest setting
  a_r6_slow_is_slowest: assert property (@(posedge clk) disable iff (rst)
    too_slow |-> (div16 && (pm == '1)));

  // R7: a zero request yields the slowest setting and the flag
  a_r7_zero_req: assert property (@(posedge clk) disable iff (rst)
    (done && req_zero_q) |-> (too_slow && div16 && (pm == '1)));

  // R10: no start is accepted while a calculation runs
  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    ((cyc != '0) && !done) |-> !start_ok);

endmodule

bind spi_rate_calc spi_rate_calc_sva #(.FREQ_W(FREQ_W), .PM_W(PM_W)) u_sva (
  .clk(clk), .rst(rst), .start_ok(start_ok), .req_zero_q(req_zero_q),
  .div16(div16), .pm(pm), .too_slow(too_slow), .done(done)
);

// File: tb/spi_rate_calc_test.sv
module spi_rate_calc_test;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W     = 32;
  localparam int PM_W       = 4;
  localparam int LAT_NEG    = FREQ_W + 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [FREQ_W-1:0] src_hz, req_hz;
  logic              div16, too_slow, done;
  logic [PM_W-1:0]   pm;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rate_calc uut (
    .clk(clk), .rst(rst), .start(start), .src_hz(src_hz), .req_hz(req_hz),
    .div16(div16), .pm(pm), .too_slow(too_slow), .done(done)
  );

  // expected {div16, pm, too_slow} from the requirements
  function automatic logic [5:0] model(longint unsigned s, longint unsigned r);
    longint unsigned c;
    if (r == 0) return {1'b1, 4'hF, 1'b1};                 // R7
    if (s == 0) return {1'b0, 4'h0, 1'b0};                 // R8
    if (s > 64 * r) begin                                  // R2
      c = (s - 1) / (64 * r) + 1;                          // R4
      if (c > 16) return {1'b1, 4'hF, 1'b1};               // R5
      return {1'b1, 4'(c - 1), 1'b0};
    end
    c = (s - 1) / (4 * r) + 1;                             // R3
    return {1'b0, 4'(c - 1), 1'b0};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] s, logic [31:0] r, string req);
    logic [5:0] exp;
    logic [5:0] act;
    int k;
    longint unsigned mult;
    exp = model(s, r);
    @(negedge clk);
    src_hz = s; req_hz = r; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(k == LAT_NEG, "R9", "done latency", k, LAT_NEG);
    act = {div16, pm, too_slow};
    check(act == exp, req, $sformatf("result src=%0d req=%0d", s, r), act, exp);
    if (!too_slow && r != 0 && s != 0) begin
      mult = div16 ? 64 : 4;
      check(longint'(s) <= longint'(r) * mult * (pm + 1), "R3",
            "derived clock above request", s, r * mult * (pm + 1));
    end
    @(negedge clk);
    check(!done, "R9", "done width", done, 0);
    check({div16, pm, too_slow} == act, "R9", "hold", {div16, pm, too_slow}, act);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] exp_a;
    int extra;
    void'($urandom(32'd20260));
    rst = 1'b1; start = 1'b0; src_hz = '0; req_hz = '0;
    repeat (3) @(negedge clk);
    check({div16, pm, too_slow, done} == 7'd0, "R1", "reset state",
          {div16, pm, too_slow, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({div16, pm, too_slow, done} == 7'd0, "R1", "after reset",
          {div16, pm, too_slow, done}, 0);

    apply(32'd133333332, 32'd10000000, "R3");  // non-exact: pm 3
    apply(32'd160000000, 32'd10000000, "R3");  // exact: pm 3
    apply(32'd40000000,  32'd10000000, "R3");  // exact: pm 0
    apply(32'd640000000, 32'd10000000, "R2");  // ratio 64: fine, pm 15
    apply(32'd640000001, 32'd10000000, "R2");  // ratio over 64: coarse, pm 1
    apply(32'd1024,      32'd1,        "R4");  // coarse count 16
    apply(32'd1025,      32'd1,        "R5");  // coarse count 17: clamp
    apply(32'd1000000000, 32'd1000,    "R5");
    apply(32'd50000000,  32'd0,        "R7");
    apply(32'd0,         32'd12345,    "R8");
    apply(32'd1,         32'd1,        "R3");
    apply(32'hFFFFFFFF,  32'hFFFFFFFF, "R3");
    apply(32'hFFFFFFFF,  32'd1,        "R6");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] s, r;
      s = $urandom;
      r = (s >> ($urandom % 14)) + 32'($urandom % 5);
      apply(s, r, (r != 0 && 64'(s) > 64 * 64'(r)) ? "R4" : "R3");
    end

    // R10: a second start mid-calculation must be dropped
    exp_a = model(64'd133333332, 64'd10000000);
    @(negedge clk);
    src_hz = 32'd133333332; req_hz = 32'd10000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    src_hz = 32'd9; req_hz = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check({div16, pm, too_slow} == exp_a, "R10", "result of first request",
          {div16, pm, too_slow}, exp_a);
    extra = 0;
    repeat (50) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R10", "extra done pulses", extra, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule